// File: doc/BRIEF.md
# Single-Entry Translation Cache with Accessed/Dirty Maintenance

This block sits in front of a page-table walker. It holds one cached virtual-to-physical translation for a three-level, 39-bit virtual address scheme. The entry is tagged with an address-space identifier and a virtual page. It keeps the page's physical base, the full 64-bit page-table entry, the physical address that entry was read from, the page level and a global flag. A lookup that hits is answered from the cache. The block checks permissions and decides whether the accessed or dirty flag must be set.

When a flag must change and the platform allows it, the block does three things in order. It writes the new entry value into the cache, issues an 8-byte store of that value to the remembered entry address, and returns the translated address once the store completes. A lookup that misses hands the access to an external walker. The walker's result is installed, after a flag update and write-back if one is needed.

A flush port invalidates the entry. The flush can be selective by address-space identifier, by virtual address, by both, or unconditional. Lookups are accepted one at a time through a ready signal. The walker and the memory store path are external ports.

Top module: `tlb_one`

## Requirements
- R1: After reset the entry is empty, `req_ready` is high and `resp_valid`, `walk_req` and `wb_valid` are low. The first lookup therefore starts a walk.
- R2: A lookup hits when the entry is valid, its identifier equals `req_asid` or its global flag is set, and `req_va` equals the stored address outside the page mask. The page mask covers bits below 12 + 9×level (level 0, 1 or 2). A hit raises no `walk_req`, and `resp_valid` rises in the cycle after acceptance. A miss raises `walk_req`.
- R3: The address returned on a hit is the stored page base ORed with `req_va` masked by the page mask, zero-extended to 56 bits.
- R4: PTE bit positions: V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7. Access codes: 0 load, 1 store, 2 or 3 fetch. The privilege test passes when the request is a user request and U=1. For a supervisor request it passes when U=0, or when `req_sum` is set and the access is not a fetch. The type test for a load passes on R, or on X with `req_mxr`. A store needs W and a fetch needs X. A hit failing either test responds with fault code 1.
- R5: An update is needed when A=0, or when the access is a store and D=0. If the hit passes R4 and needs an update while `upd_en` is low, the response is fault code 2 and no store is issued.
- R6: If the hit passes R4 and needs an update while `upd_en` is high, the cached entry takes the new value (A set, and D set for stores). `wb_valid` then presents `wb_addr` set to the stored entry address and `wb_data` set to the new value. On `wb_done` the translated address is returned with fault code 0. If `wb_err` is set, fault code 3 is returned instead.
- R7: On a miss, `walk_req` stays high until `walk_done`. A nonzero `walk_fault` is returned unchanged as the fault code and nothing is installed.
- R8: A successful walk needing no update installs the walk result and returns `walk_pa`. The installed base is `walk_pa` with the page-mask bits cleared.
- R9: A successful walk needing an update returns fault code 2 when `upd_en` is low. When `upd_en` is high, the block writes the new value to `walk_pte_addr`. With `wb_err` the response is fault code 3 and nothing is installed. Otherwise the updated entry is installed and `walk_pa` is returned.
- R10: A flush clears the entry only if every selector given matches. The identifier selector matches an equal identifier on a non-global entry. The address selector matches when the address agrees outside the entry's page mask. With no selector the flush always clears.
- R11: `req_ready` is low while a walk or a write-back is outstanding.
- R12: A flush in the same cycle as an accepted lookup does not change that lookup's result. A flush in the same cycle as an install leaves the new entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_en | input | 1 | Platform permission for hardware A/D updates |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a lookup |
| req_asid | input | 16 | Requesting address-space identifier |
| req_va | input | 39 | Virtual address |
| req_acc | input | 2 | Access kind (0 load, 1 store, 2/3 fetch) |
| req_user | input | 1 | Request made at user privilege |
| req_mxr | input | 1 | Executable pages readable |
| req_sum | input | 1 | Supervisor may touch user pages |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_pa | output | 56 | Translated physical address (0 on fault) |
| resp_fault | output | 3 | 0 ok, 1 permission, 2 update disabled, 3 access, other walker codes |
| walk_req | output | 1 | Walk requested, held until done |
| walk_va | output | 39 | Address to walk |
| walk_acc | output | 2 | Access kind for the walker |
| walk_user | output | 1 | Privilege for the walker |
| walk_mxr | output | 1 | MXR flag for the walker |
| walk_sum | output | 1 | SUM flag for the walker |
| walk_done | input | 1 | Walk finished this cycle |
| walk_fault | input | 3 | Walker fault code, 0 for success |
| walk_pa | input | 56 | Walk result physical address |
| walk_pte | input | 64 | Leaf entry found |
| walk_pte_addr | input | 56 | Physical address of the leaf entry |
| walk_level | input | 2 | Level of the leaf (0 = 4 KiB) |
| walk_global | input | 1 | Global flag of the translation |
| wb_valid | output | 1 | Entry write-back request, held until done |
| wb_addr | output | 56 | Write-back address |
| wb_data | output | 64 | Write-back value (8 bytes) |
| wb_done | input | 1 | Write-back finished this cycle |
| wb_err | input | 1 | Write-back failed |
| flush_valid | input | 1 | Flush strobe |
| flush_use_asid | input | 1 | Apply identifier selector |
| flush_asid | input | 16 | Identifier selector |
| flush_use_va | input | 1 | Apply address selector |
| flush_va | input | 39 | Address selector |

## Verification
A flush can coincide with the two functions that read or write the entry. One is a lookup accepted in the same cycle, which must still be answered from the old entry. The other is the install at the end of a walk, which must survive the flush. The bench provokes both on purpose. It raises an unconditional flush together with a hitting request, and again in the exact cycle it returns `walk_done`. It judges the outcome from the response address and from whether the next lookup to the same page raises `walk_req`.

// File: rtl/tlb_one_pkg.sv
// Shared constants, entry type and page-mask helper for the single-entry
// translation cache. Assumes a three-level 39-bit virtual scheme.
package tlb_one_pkg;
    localparam int ASID_W   = 16;
    localparam int VA_W     = 39;
    localparam int PA_W     = 56;
    localparam int PTE_W    = 64;
    localparam int LVL_W    = 2;
    localparam int PG_OFS   = 12;
    localparam int LVL_BITS = 9;
    localparam int EXT_W    = PA_W - VA_W;

    // Bit positions inside the low byte of a page-table entry
    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_G = 5;
    localparam int B_A = 6;
    localparam int B_D = 7;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;

    localparam logic [2:0] FLT_NONE   = 3'd0;
    localparam logic [2:0] FLT_PERM   = 3'd1;
    localparam logic [2:0] FLT_UPD    = 3'd2;
    localparam logic [2:0] FLT_ACCESS = 3'd3;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   pa;
        logic [PTE_W-1:0]  pte;
        logic [PA_W-1:0]   pte_addr;
        logic [LVL_W-1:0]  level;
        logic              glob;
    } tlb_ent_t;

    // Mask of the in-page offset bits for a given level (levels above 2 clamp)
    function automatic logic [VA_W-1:0] lvl_mask(input logic [LVL_W-1:0] lvl);
        logic [VA_W-1:0] m;
        int top;
        top = PG_OFS + LVL_BITS * ((lvl == 2'd0) ? 0 : (lvl == 2'd1) ? 1 : 2);
        for (int i = 0; i < VA_W; i++) m[i] = (i < top);
        return m;
    endfunction
endpackage

// File: rtl/tlb_one_perm.sv
// Permission and accessed/dirty decision for one page-table entry.
// Purely combinational; assumes the entry is a valid leaf.
module tlb_one_perm
    import tlb_one_pkg::*;
(
    input  logic [7:0] pte_lo,
    input  logic [1:0] acc,
    input  logic       user,
    input  logic       mxr,
    input  logic       sum,
    output logic       ok,
    output logic       need,
    output logic [7:0] new_lo
);
    logic priv_ok;
    logic type_ok;
    logic is_store;
    logic is_fetch;

    // Privilege test, access-type test and the flag update decision
    always_comb begin
        is_store = (acc == ACC_STORE);
        is_fetch = acc[1];
        priv_ok  = user ? pte_lo[B_U] : (!pte_lo[B_U] || (sum && !is_fetch));
        if (acc == ACC_LOAD)  type_ok = pte_lo[B_R] || (mxr && pte_lo[B_X]);
        else if (is_store)    type_ok = pte_lo[B_W];
        else                  type_ok = pte_lo[B_X];
        ok     = priv_ok && type_ok;
        need   = !pte_lo[B_A] || (is_store && !pte_lo[B_D]);
        new_lo = pte_lo;
        new_lo[B_A] = 1'b1;
        if (is_store) new_lo[B_D] = 1'b1;
    end
endmodule

// File: rtl/tlb_one_entry.sv
// Storage for the single cached translation with lookup match and flush
// match. Install takes priority over a flush in the same cycle.
module tlb_one_entry
    import tlb_one_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic [PA_W-1:0]   e_pa,
    output logic [PTE_W-1:0]  e_pte,
    output logic [PA_W-1:0]   e_pte_addr,
    output logic [VA_W-1:0]   e_mask,
    input  logic              ins_en,
    input  tlb_ent_t          ins_ent,
    input  logic              pte_wr_en,
    input  logic [PTE_W-1:0]  pte_wr_val,
    input  logic              fl_valid,
    input  logic              fl_use_asid,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_use_va,
    input  logic [VA_W-1:0]   fl_va
);
    tlb_ent_t q;
    logic     vld;
    logic     fl_match;

    // Lookup and flush matching against the stored tag
    always_comb begin
        e_mask   = lvl_mask(q.level);
        lk_hit   = vld && (q.glob || (lk_asid == q.asid))
                       && (((lk_va ^ q.va) & ~e_mask) == '0);
        fl_match = vld
                 && (!fl_use_asid || ((fl_asid == q.asid) && !q.glob))
                 && (!fl_use_va || (((fl_va ^ q.va) & ~e_mask) == '0));
        e_pa       = q.pa;
        e_pte      = q.pte;
        e_pte_addr = q.pte_addr;
    end

    // Entry update: flush, then in-place entry rewrite, then install wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            q   <= '0;
        end else begin
            if (fl_valid && fl_match) vld <= 1'b0;
            if (pte_wr_en) q.pte <= pte_wr_val;
            if (ins_en) begin
                vld <= 1'b1;
                q   <= ins_ent;
            end
        end
    end

    AST_INSTALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> vld); // R8
    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid && !fl_use_asid && !fl_use_va && !ins_en |=> !vld); // R10
    AST_GLOBAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        vld && q.glob && fl_valid && fl_use_asid && !fl_use_va && !ins_en |=> vld); // R10
    AST_INSTALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en && fl_valid |=> vld); // R12
endmodule

// File: rtl/tlb_one.sv
// Single-entry translation cache front end. Serves hits from the stored
// entry, performs hardware A/D updates with write-back when enabled, and
// hands misses to an external walker. One lookup in flight at a time.
module tlb_one
    import tlb_one_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic              req_mxr,
    input  logic              req_sum,
    output logic              resp_valid,
    output logic [PA_W-1:0]   resp_pa,
    output logic [2:0]        resp_fault,
    output logic              walk_req,
    output logic [VA_W-1:0]   walk_va,
    output logic [1:0]        walk_acc,
    output logic              walk_user,
    output logic              walk_mxr,
    output logic              walk_sum,
    input  logic              walk_done,
    input  logic [2:0]        walk_fault,
    input  logic [PA_W-1:0]   walk_pa,
    input  logic [PTE_W-1:0]  walk_pte,
    input  logic [PA_W-1:0]   walk_pte_addr,
    input  logic [LVL_W-1:0]  walk_level,
    input  logic              walk_global,
    output logic              wb_valid,
    output logic [PA_W-1:0]   wb_addr,
    output logic [PTE_W-1:0]  wb_data,
    input  logic              wb_done,
    input  logic              wb_err,
    input  logic              flush_valid,
    input  logic              flush_use_asid,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              flush_use_va,
    input  logic [VA_W-1:0]   flush_va
);
    typedef enum logic [1:0] {S_IDLE, S_WALK, S_WB} st_t;

    st_t               st;
    logic [ASID_W-1:0] q_asid;
    logic [VA_W-1:0]   q_va;
    logic [1:0]        q_acc;
    logic              q_user, q_mxr, q_sum, q_from_hit;
    logic [PA_W-1:0]   q_pa;
    logic [PA_W-1:0]   q_wb_addr;
    logic [PTE_W-1:0]  q_wb_data;
    tlb_ent_t          q_ent;

    logic              lk_hit;
    logic [PA_W-1:0]   e_pa, e_pte_addr, hit_pa;
    logic [PTE_W-1:0]  e_pte, pte_wr_val;
    logic [VA_W-1:0]   e_mask, w_mask;
    logic              accept, pc_ok, pc_need;
    logic [7:0]        pc_lo, pc_new;
    logic [1:0]        pc_acc;
    logic              pc_user, pc_mxr, pc_sum;
    logic              ins_en, pte_wr_en;
    tlb_ent_t          walk_ent, ins_ent;

    tlb_one_entry u_entry (
        .clk(clk), .rst_n(rst_n),
        .lk_asid(req_asid), .lk_va(req_va), .lk_hit(lk_hit),
        .e_pa(e_pa), .e_pte(e_pte), .e_pte_addr(e_pte_addr), .e_mask(e_mask),
        .ins_en(ins_en), .ins_ent(ins_ent),
        .pte_wr_en(pte_wr_en), .pte_wr_val(pte_wr_val),
        .fl_valid(flush_valid), .fl_use_asid(flush_use_asid), .fl_asid(flush_asid),
        .fl_use_va(flush_use_va), .fl_va(flush_va)
    );

    tlb_one_perm u_perm (
        .pte_lo(pc_lo), .acc(pc_acc), .user(pc_user), .mxr(pc_mxr), .sum(pc_sum),
        .ok(pc_ok), .need(pc_need), .new_lo(pc_new)
    );

    // Port-facing status derived from the controller state
    always_comb begin
        req_ready = (st == S_IDLE);
        walk_req  = (st == S_WALK);
        wb_valid  = (st == S_WB);
        walk_va   = q_va;
        walk_acc  = q_acc;
        walk_user = q_user;
        walk_mxr  = q_mxr;
        walk_sum  = q_sum;
        wb_addr   = q_wb_addr;
        wb_data   = q_wb_data;
        accept    = req_valid && req_ready;
    end

    // Select the entry under check: cached one while idle, walk result later
    always_comb begin
        pc_lo   = (st == S_IDLE) ? e_pte[7:0] : walk_pte[7:0];
        pc_acc  = (st == S_IDLE) ? req_acc    : q_acc;
        pc_user = (st == S_IDLE) ? req_user   : q_user;
        pc_mxr  = (st == S_IDLE) ? req_mxr    : q_mxr;
        pc_sum  = (st == S_IDLE) ? req_sum    : q_sum;
    end

    // Address forming, install data and entry write controls
    always_comb begin
        hit_pa     = e_pa | {{EXT_W{1'b0}}, req_va & e_mask};
        w_mask     = lvl_mask(walk_level);
        pte_wr_val = {e_pte[PTE_W-1:8], pc_new};
        walk_ent.asid     = q_asid;
        walk_ent.va       = q_va;
        walk_ent.pa       = walk_pa & ~{{EXT_W{1'b0}}, w_mask};
        walk_ent.pte      = walk_pte;
        walk_ent.pte_addr = walk_pte_addr;
        walk_ent.level    = walk_level;
        walk_ent.glob     = walk_global;
        pte_wr_en = (st == S_IDLE) && accept && lk_hit && pc_ok && pc_need && upd_en;
        ins_en    = ((st == S_WALK) && walk_done && (walk_fault == FLT_NONE) && !pc_need)
                 || ((st == S_WB) && wb_done && !wb_err && !q_from_hit);
        ins_ent   = (st == S_WB) ? q_ent : walk_ent;
    end

    // Lookup sequencing: idle decision, walk wait, write-back wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            resp_valid <= 1'b0;
            resp_pa    <= '0;
            resp_fault <= FLT_NONE;
            q_asid     <= '0;
            q_va       <= '0;
            q_acc      <= '0;
            q_user     <= 1'b0;
            q_mxr      <= 1'b0;
            q_sum      <= 1'b0;
            q_from_hit <= 1'b0;
            q_pa       <= '0;
            q_wb_addr  <= '0;
            q_wb_data  <= '0;
            q_ent      <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (st)
                S_IDLE: if (accept) begin
                    q_asid <= req_asid;
                    q_va   <= req_va;
                    q_acc  <= req_acc;
                    q_user <= req_user;
                    q_mxr  <= req_mxr;
                    q_sum  <= req_sum;
                    resp_pa <= '0;
                    if (!lk_hit) begin
                        st         <= S_WALK;
                        q_from_hit <= 1'b0;
                    end else if (!pc_ok) begin
                        resp_valid <= 1'b1;
                        resp_fault <= FLT_PERM;
                    end else if (pc_need && !upd_en) begin
                        resp_valid <= 1'b1;
                        resp_fault <= FLT_UPD;
                    end else if (pc_need) begin
                        st         <= S_WB;
                        q_from_hit <= 1'b1;
                        q_pa       <= hit_pa;
                        q_wb_addr  <= e_pte_addr;
                        q_wb_data  <= pte_wr_val;
                    end else begin
                        resp_valid <= 1'b1;
                        resp_fault <= FLT_NONE;
                        resp_pa    <= hit_pa;
                    end
                end
                S_WALK: if (walk_done) begin
                    resp_pa <= '0;
                    if (walk_fault != FLT_NONE) begin
                        st         <= S_IDLE;
                        resp_valid <= 1'b1;
                        resp_fault <= walk_fault;
                    end else if (!pc_need) begin
                        st         <= S_IDLE;
                        resp_valid <= 1'b1;
                        resp_fault <= FLT_NONE;
                        resp_pa    <= walk_pa;
                    end else if (!upd_en) begin
                        st         <= S_IDLE;
                        resp_valid <= 1'b1;
                        resp_fault <= FLT_UPD;
                    end else begin
                        st        <= S_WB;
                        q_pa      <= walk_pa;
                        q_wb_addr <= walk_pte_addr;
                        q_wb_data <= {walk_pte[PTE_W-1:8], pc_new};
                        q_ent     <= walk_ent;
                        q_ent.pte <= {walk_pte[PTE_W-1:8], pc_new};
                    end
                end
                S_WB: if (wb_done) begin
                    st         <= S_IDLE;
                    resp_valid <= 1'b1;
                    resp_fault <= wb_err ? FLT_ACCESS : FLT_NONE;
                    resp_pa    <= wb_err ? '0 : q_pa;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !lk_hit |=> walk_req); // R2
    AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && lk_hit |=> !walk_req); // R2
    AST_UPD_OFF_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && lk_hit && pc_ok && pc_need && !upd_en
        |=> !wb_valid && resp_valid && (resp_fault == FLT_UPD)); // R5
    AST_WB_SETS_A: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_data[B_A]); // R6
    AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_done |=> walk_req); // R7
    AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_done |=> wb_valid && $stable(wb_data)); // R6
endmodule

// File: tb/tlb_one_bench.sv
`timescale 1ns/1ps
module tlb_one_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_asid = '0;
    logic [38:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0, req_mxr = 1'b0, req_sum = 1'b0;
    logic        resp_valid;
    logic [55:0] resp_pa;
    logic [2:0]  resp_fault;
    logic        walk_req;
    logic [38:0] walk_va;
    logic [1:0]  walk_acc;
    logic        walk_user, walk_mxr, walk_sum;
    logic        walk_done = 1'b0;
    logic [2:0]  walk_fault = '0;
    logic [55:0] walk_pa = '0;
    logic [63:0] walk_pte = '0;
    logic [55:0] walk_pte_addr = '0;
    logic [1:0]  walk_level = '0;
    logic        walk_global = 1'b0;
    logic        wb_valid;
    logic [55:0] wb_addr;
    logic [63:0] wb_data;
    logic        wb_done = 1'b0, wb_err = 1'b0;
    logic        flush_valid = 1'b0, flush_use_asid = 1'b0, flush_use_va = 1'b0;
    logic [15:0] flush_asid = '0;
    logic [38:0] flush_va = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference entry kept by the bench
    bit          m_v = 0, m_g = 0;
    logic [15:0] m_asid = '0;
    logic [38:0] m_va = '0;
    logic [55:0] m_base = '0, m_paddr = '0;
    logic [63:0] m_pte = '0;
    int          m_lv = 0;

    // Walker and memory behaviour for the next lookup
    logic [2:0]  k_fault = '0;
    int          k_lv = 0;
    logic [55:0] k_base = '0, k_paddr = '0;
    logic [63:0] k_pte = '0;
    bit          k_g = 0, k_wberr = 0;

    tlb_one u_tlb_one (.*);

    always #4 clk = ~clk;

    function automatic logic [38:0] b_mask(int lv);
        return 39'((64'd1 << (12 + 9 * lv)) - 64'd1);
    endfunction

    function automatic bit b_perm(logic [7:0] p, logic [1:0] ac, bit us, bit mx, bit sm);
        bit pv, ty;
        pv = us ? p[4] : (!p[4] || (sm && ac[1] == 1'b0));
        if (ac == 2'd0)      ty = p[1] || (mx && p[3]);
        else if (ac == 2'd1) ty = p[2];
        else                 ty = p[3];
        return pv && ty;
    endfunction

    function automatic bit b_need(logic [7:0] p, logic [1:0] ac);
        return !p[6] || (ac == 2'd1 && !p[7]);
    endfunction

    function automatic logic [7:0] b_new(logic [7:0] p, logic [1:0] ac);
        return p | 8'h40 | ((ac == 2'd1) ? 8'h80 : 8'h00);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic install(input logic [15:0] a, input logic [38:0] v, input logic [63:0] p);
        m_v = 1; m_asid = a; m_va = v; m_pte = p; m_paddr = k_paddr;
        m_lv = k_lv; m_g = k_g;
        m_base = k_base & ~{17'd0, b_mask(k_lv)};
    endtask

    // One lookup; flm 0 none, 1 unconditional flush with the request,
    // 2 unconditional flush in the walk_done cycle
    task automatic run_req(input logic [15:0] a, input logic [38:0] v, input logic [1:0] ac,
                           input bit us, input bit mx, input bit sm, input int flm, input string rq);
        logic [38:0] mk;
        logic [55:0] epa, ewa, wpa;
        logic [63:0] ewd;
        logic [2:0]  ef, af;
        logic [55:0] apa;
        bit hit, pok, need, ewalk, ewb, got, walked, wbd;
        ewb = 0; ewa = '0; ewd = '0; ef = '0; af = '0; apa = '0;
        hit = m_v && (m_g || a == m_asid) && (((v ^ m_va) & ~b_mask(m_lv)) == '0);
        wpa = (k_base & ~{17'd0, b_mask(k_lv)}) | {17'd0, v & b_mask(k_lv)};
        if (hit) begin
            ewalk = 0;
            mk  = b_mask(m_lv);
            pok = b_perm(m_pte[7:0], ac, us, mx, sm);
            need = b_need(m_pte[7:0], ac);
            epa = m_base | {17'd0, v & mk};
            if (!pok) ef = 3'd1;
            else if (need && !upd_en) ef = 3'd2;
            else if (need) begin
                ewb = 1; ewa = m_paddr; ewd = {m_pte[63:8], b_new(m_pte[7:0], ac)};
                ef = k_wberr ? 3'd3 : 3'd0;
            end
            if (flm == 1) m_v = 0;
            if (pok && need && upd_en) m_pte = ewd;
        end else begin
            ewalk = 1;
            epa = wpa;
            if (flm != 0) m_v = 0;
            if (k_fault != 3'd0) ef = k_fault;
            else begin
                need = b_need(k_pte[7:0], ac);
                if (!need) install(a, v, k_pte);
                else if (!upd_en) ef = 3'd2;
                else begin
                    ewb = 1; ewa = k_paddr; ewd = {k_pte[63:8], b_new(k_pte[7:0], ac)};
                    if (k_wberr) ef = 3'd3;
                    else install(a, v, ewd);
                end
            end
        end
        @(negedge clk);
        req_valid = 1; req_asid = a; req_va = v; req_acc = ac;
        req_user = us; req_mxr = mx; req_sum = sm;
        if (flm == 1) begin
            flush_valid = 1; flush_use_asid = 0; flush_use_va = 0;
        end
        @(negedge clk);
        req_valid = 0; flush_valid = 0;
        got = 0; walked = 0; wbd = 0;
        for (int n = 0; n < 40 && !got; n++) begin
            walk_done = 0; wb_done = 0; wb_err = 0; flush_valid = 0;
            if (resp_valid) begin
                got = 1; af = resp_fault; apa = resp_pa;
            end else begin
                if (walk_req && !walked) begin
                    walked = 1;
                    chk(!req_ready, "R11", "ready during walk", 64'(req_ready), 64'd0);
                    chk(walk_va == v, "R7", "walk address", 64'(walk_va), 64'(v));
                    walk_done = 1; walk_fault = k_fault; walk_pa = wpa; walk_pte = k_pte;
                    walk_pte_addr = k_paddr; walk_level = 2'(k_lv); walk_global = k_g;
                    if (flm == 2) begin
                        flush_valid = 1; flush_use_asid = 0; flush_use_va = 0;
                    end
                end
                if (wb_valid && !wbd) begin
                    wbd = 1;
                    chk(!req_ready, "R11", "ready during write-back", 64'(req_ready), 64'd0);
                    chk(wb_addr == ewa, "R6", "write-back address", 64'(wb_addr), 64'(ewa));
                    chk(wb_data == ewd, "R6", "write-back data", wb_data, ewd);
                    wb_done = 1; wb_err = k_wberr;
                end
                @(negedge clk);
            end
        end
        walk_done = 0; wb_done = 0; wb_err = 0; flush_valid = 0;
        chk(got, "R2", {rq, " response seen"}, 64'(got), 64'd1);
        chk(walked == ewalk, "R2", {rq, " walk issued"}, 64'(walked), 64'(ewalk));
        chk(wbd == ewb, "R5", {rq, " write-back issued"}, 64'(wbd), 64'(ewb));
        chk(af == ef, rq, "fault code", 64'(af), 64'(ef));
        if (ef == 3'd0) chk(apa == epa, rq, "physical address", 64'(apa), 64'(epa));
    endtask

    task automatic do_flush(input bit ua, input logic [15:0] fa, input bit uv, input logic [38:0] fv);
        bit mt;
        mt = m_v && (!ua || (fa == m_asid && !m_g))
                 && (!uv || (((fv ^ m_va) & ~b_mask(m_lv)) == '0));
        if (mt) m_v = 0;
        @(negedge clk);
        flush_valid = 1; flush_use_asid = ua; flush_asid = fa; flush_use_va = uv; flush_va = fv;
        @(negedge clk);
        flush_valid = 0; flush_use_asid = 0; flush_use_va = 0;
    endtask

    task automatic set_walk(input int lv, input logic [7:0] lo, input bit g);
        k_fault = '0; k_lv = lv; k_g = g; k_wberr = 0;
        k_base = 56'h00AB_CDEF_1234_5000 + 56'(lv) * 56'h1000_0000;
        k_paddr = 56'h0000_0080_0000_0100 + 56'(lv) * 8;
        k_pte = {56'h0000_1234_5678_9A, lo};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R1", "resp after reset", 64'(resp_valid), 64'd0);
        chk(walk_req == 1'b0, "R1", "walk after reset", 64'(walk_req), 64'd0);
        chk(wb_valid == 1'b0, "R1", "wb after reset", 64'(wb_valid), 64'd0);

        // R1/R8: first lookup walks and installs; R2/R3: hit, other ASID misses
        set_walk(0, 8'hCF, 0);
        run_req(16'd1, 39'h12_3456_7ABC, 2'd0, 0, 0, 0, 0, "R8");
        run_req(16'd1, 39'h12_3456_7123, 2'd0, 0, 0, 0, 0, "R3");
        run_req(16'd2, 39'h12_3456_7123, 2'd0, 0, 0, 0, 0, "R2");

        // R3: level-2 superpage combines 30 offset bits
        set_walk(2, 8'hCF, 0);
        run_req(16'd3, 39'h40_0000_0000, 2'd0, 0, 0, 0, 0, "R8");
        run_req(16'd3, 39'h40_3FF5_A678, 2'd0, 0, 0, 0, 0, "R3");

        // R4: read of execute-only page, with and without MXR; user page from supervisor
        set_walk(0, 8'hC9, 0);
        run_req(16'd4, 39'h01_0000_0000, 2'd2, 0, 0, 0, 0, "R8");
        run_req(16'd4, 39'h01_0000_0010, 2'd0, 0, 0, 0, 0, "R4");
        run_req(16'd4, 39'h01_0000_0010, 2'd0, 0, 1, 0, 0, "R4");
        set_walk(0, 8'hD7, 0);
        run_req(16'd4, 39'h02_0000_0000, 2'd0, 1, 0, 0, 0, "R8");
        run_req(16'd4, 39'h02_0000_0008, 2'd0, 0, 0, 0, 0, "R4");
        run_req(16'd4, 39'h02_0000_0008, 2'd0, 0, 0, 1, 0, "R4");

        // R5/R6: store to a clean page, disabled then enabled, then already dirty
        set_walk(0, 8'h47, 0);
        run_req(16'd5, 39'h03_0000_0000, 2'd0, 0, 0, 0, 0, "R8");
        upd_en = 0;
        run_req(16'd5, 39'h03_0000_0040, 2'd1, 0, 0, 0, 0, "R5");
        upd_en = 1;
        run_req(16'd5, 39'h03_0000_0040, 2'd1, 0, 0, 0, 0, "R6");
        run_req(16'd5, 39'h03_0000_0048, 2'd1, 0, 0, 0, 0, "R6");
        k_wberr = 1;
        set_walk(0, 8'h07, 0); k_wberr = 0;
        run_req(16'd5, 39'h04_0000_0000, 2'd1, 0, 0, 0, 0, "R9");
        set_walk(0, 8'h0F, 0);
        run_req(16'd6, 39'h05_0000_0000, 2'd0, 0, 0, 0, 0, "R8");
        k_wberr = 1;
        run_req(16'd6, 39'h05_0000_0000, 2'd0, 0, 0, 0, 0, "R6");
        k_wberr = 0;

        // R7: walker fault passed, nothing installed
        set_walk(0, 8'hCF, 0); k_fault = 3'd5;
        run_req(16'd7, 39'h06_0000_0000, 2'd0, 0, 0, 0, 0, "R7");
        k_fault = 3'd0;
        run_req(16'd7, 39'h06_0000_0000, 2'd0, 0, 0, 0, 0, "R7");

        // R9: walk needing update: disabled, write-back error, success
        set_walk(1, 8'h0F, 0);
        upd_en = 0;
        run_req(16'd8, 39'h07_0000_0000, 2'd0, 0, 0, 0, 0, "R9");
        upd_en = 1; k_wberr = 1;
        run_req(16'd8, 39'h07_0000_0000, 2'd0, 0, 0, 0, 0, "R9");
        k_wberr = 0;
        run_req(16'd8, 39'h07_0000_0000, 2'd1, 0, 0, 0, 0, "R9");
        run_req(16'd8, 39'h07_001F_F000, 2'd1, 0, 0, 0, 0, "R9");

        // R10: flush selectors, global exemption
        set_walk(0, 8'hEF, 1);
        run_req(16'd9, 39'h08_0000_0000, 2'd0, 0, 0, 0, 0, "R10");
        do_flush(1, 16'd9, 0, '0);
        run_req(16'd2, 39'h08_0000_0010, 2'd0, 0, 0, 0, 0, "R10");
        do_flush(0, '0, 1, 39'h08_0000_1000);
        run_req(16'd9, 39'h08_0000_0010, 2'd0, 0, 0, 0, 0, "R10");
        do_flush(0, '0, 1, 39'h08_0000_0FF8);
        run_req(16'd9, 39'h08_0000_0010, 2'd0, 0, 0, 0, 0, "R10");
        set_walk(0, 8'hCF, 0);
        run_req(16'd9, 39'h09_0000_0000, 2'd0, 0, 0, 0, 0, "R10");
        do_flush(1, 16'd3, 1, 39'h09_0000_0000);
        run_req(16'd9, 39'h09_0000_0000, 2'd0, 0, 0, 0, 0, "R10");
        do_flush(1, 16'd9, 1, 39'h09_0000_0000);
        run_req(16'd9, 39'h09_0000_0000, 2'd0, 0, 0, 0, 0, "R10");
        do_flush(0, '0, 0, '0);
        run_req(16'd9, 39'h09_0000_0000, 2'd0, 0, 0, 0, 0, "R10");

        // R12: flush beside a hit and beside an install
        run_req(16'd9, 39'h09_0000_0020, 2'd0, 0, 0, 0, 1, "R12");
        run_req(16'd9, 39'h09_0000_0020, 2'd0, 0, 0, 0, 2, "R12");
        run_req(16'd9, 39'h09_0000_0028, 2'd0, 0, 0, 0, 0, "R12");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [38:0] v;
            logic [15:0] a;
            logic [1:0]  ac;
            v  = (39'($urandom_range(0, 3)) << 30) | (39'($urandom_range(0, 1)) << 21)
               | (39'($urandom_range(0, 1)) << 12) | 39'($urandom & 32'hFFF);
            a  = 16'($urandom_range(1, 2));
            ac = 2'($urandom_range(0, 2));
            k_lv = $urandom_range(0, 2);
            k_base = {24'($urandom), 32'($urandom)};
            k_paddr = {24'($urandom), 29'($urandom), 3'b000};
            k_pte = {32'($urandom), 24'($urandom), 8'($urandom) | 8'h01};
            k_g = ($urandom_range(0, 5) == 0);
            k_fault = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(4, 7)) : 3'd0;
            k_wberr = ($urandom_range(0, 7) == 0);
            upd_en = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 9) == 0)
                do_flush($urandom_range(0, 1) == 1, 16'($urandom_range(1, 2)),
                         $urandom_range(0, 1) == 1, v);
            run_req(a, v, ac, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                    $urandom_range(0, 1) == 1, $urandom_range(0, 6) == 0 ? 1 : 0, "R4");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule